// File: doc/BRIEF.md
# Delta-Sigma Resonator Sine Oscillator

This block makes a low-frequency sine stimulus and delivers it as a single oversampled bit per clock. The tone comes from a loop of two cascaded integrators that forms a lossless digital resonator. A first-order delta-sigma quantizer sits inside that loop. Its one-bit decision (plus or minus full scale) stands in for the multi-bit resonator state on the feedback path. The frequency multiply therefore reduces to choosing between adding and subtracting a step. An external analog low-pass filter recovers the sine from the bit stream.

The block runs from a fast square clock, nominally 12.8 MHz, which may be divided by an integer from 1 to 8 before it arrives, to reach lower tones. A 7-bit frequency code sets the loop coefficient. A 7-bit level code sets the starting amplitude through the value seeded into the second integrator. Both codes are captured only on a synchronous restart pulse. Power-down and external-source selection each put the generator into an idle state with its integrators cleared and its output held low.

Top module: `dsres_osc`

## Requirements
- R1: While `rst_ni` is low, `bs_o` is 0. After release, the block seeds itself and starts oscillating with frequency code 96 and level code 64, without any restart pulse.
- R2: While `pwr_down_i` is high, `bs_o` is 0 from the next rising edge on, and both integrators hold zero.
- R3: While `ext_sel_i` is high, the internal generator is idle in the same way: `bs_o` is 0 from the next edge on, and the integrators hold zero.
- R4: With frequency code F (loop coefficient k = F·2^-18), the tone period is 2π / acos(1 − F/2^19) clock cycles, within ±4 %. Code 96 gives about 39 kHz from 12.8 MHz, and code 127 gives about 44.8 kHz.
- R5: With level code L, the second integrator is seeded to L·2^12, where full scale is 2^20. The local mean of the stream, with a 1 bit read as +1 and a 0 bit read as −1, therefore swings with a peak of about L/256 of full scale.
- R6: A one-cycle `restart_i` captures both codes at that edge. If the block is not idle, the same edge reseeds the state: first integrator 0, second integrator L·2^12, quantizer residue 0. A restart while idle, including in the same cycle that idle is entered, still captures the codes, and the next enable uses them.
- R7: A change on `freq_code_i` or `lvl_code_i` without a restart has no effect on the tone.
- R8: All integrator and residue arithmetic saturates instead of wrapping. The quantizer residue stays within [−2^20, 2^20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock (divided square clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | High stops the generator and clears its state |
| ext_sel_i | input | 1 | High selects the external source; internal generator idles |
| restart_i | input | 1 | One-cycle pulse: capture codes and reseed |
| freq_code_i | input | 7 | Frequency code, loop coefficient F·2^-18 |
| lvl_code_i | input | 7 | Level code, seed L·2^12 |
| bs_o | output | 1 | Registered one-bit delta-sigma output stream |

## Verification
A restart pulse and an idle request (power-down or external select) can land on the same edge. One asks for a reseed and the other for a cleared state. The bench drives both in one cycle with new codes on the inputs and requires `bs_o` to stay low during idle. After idle is released, with the code inputs changed again but no further restart, it requires the measured tone to match the codes captured at that shared edge. Tone period and amplitude are judged by filtering the stream in the bench with a 64-sample moving sum and timing hysteresis crossings over four periods.

// File: rtl/dsres_pkg.sv
package dsres_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Codes loaded at reset.
    localparam int unsigned DEF_FREQ_CODE = 96;
    localparam int unsigned DEF_LVL_CODE  = 64;

endpackage

// File: rtl/dsres_quant.sv
module dsres_quant #(
    parameter int unsigned ACC_W  = 23,
    parameter int unsigned FRAC_W = 20
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic signed [ACC_W-1:0] x_i,
    output logic                    bit_o,
    output logic signed [ACC_W-1:0] resid_o
);
    localparam logic signed [ACC_W-1:0] FS_P = ACC_W'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0] FS_N = -FS_P;

    typedef struct packed {
        logic signed [ACC_W-1:0] resid;
    } quant_t;

    quant_t s_d, s_q;
    logic signed [ACC_W-1:0] sum_v;

    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a,
        input logic signed [ACC_W-1:0] b
    );
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            sat_add = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else
            sat_add = s[ACC_W-1:0];
    endfunction

    always_comb begin
        s_d   = s_q;
        sum_v = sat_add(s_q.resid, x_i);
        bit_o = ~sum_v[ACC_W-1];
        // Residue keeps what the one-bit decision missed.
        s_d.resid = clr_i ? '0 : sat_add(sum_v, bit_o ? FS_N : FS_P);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign resid_o = s_q.resid;

endmodule

// File: rtl/dsres_core.sv
module dsres_core #(
    parameter int unsigned ACC_W   = 23,
    parameter int unsigned FRAC_W  = 20,
    parameter int unsigned FREQ_W  = 7,
    parameter int unsigned LVL_W   = 7,
    parameter int unsigned K_SHIFT = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    seed_i,
    input  logic                    fb_bit_i,
    input  logic [FREQ_W-1:0]       freq_i,
    input  logic [LVL_W-1:0]        lvl_i,
    output logic signed [ACC_W-1:0] x1_o,
    output logic signed [ACC_W-1:0] x2_o
);
    localparam int unsigned STEP_SH = FRAC_W - K_SHIFT;
    localparam int unsigned SEED_SH = FRAC_W - LVL_W - 1;

    typedef struct packed {
        logic signed [ACC_W-1:0] x1;
        logic signed [ACC_W-1:0] x2;
    } core_t;

    core_t s_d, s_q;
    logic signed [ACC_W-1:0] step_v, seed_v, x1_n;

    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a,
        input logic signed [ACC_W-1:0] b
    );
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            sat_add = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else
            sat_add = s[ACC_W-1:0];
    endfunction

    always_comb begin
        s_d    = s_q;
        // k times full scale: the only product the loop ever needs.
        step_v = $signed(ACC_W'(freq_i) << STEP_SH);
        seed_v = $signed(ACC_W'(lvl_i) << SEED_SH);
        x1_n   = sat_add(s_q.x1, fb_bit_i ? -step_v : step_v);
        if (clr_i) begin
            s_d.x1 = '0;
            s_d.x2 = '0;
        end else if (seed_i) begin
            s_d.x1 = '0;
            s_d.x2 = seed_v;
        end else begin
            s_d.x1 = x1_n;
            s_d.x2 = sat_add(s_q.x2, x1_n);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign x1_o = s_q.x1;
    assign x2_o = s_q.x2;

endmodule

// File: rtl/dsres_osc.sv
module dsres_osc
    import dsres_pkg::*;
#(
    parameter int unsigned FREQ_W  = 7,
    parameter int unsigned LVL_W   = 7,
    parameter int unsigned FRAC_W  = 20,
    parameter int unsigned GUARD_W = 3,
    parameter int unsigned K_SHIFT = 18
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_down_i,
    input  logic              ext_sel_i,
    input  logic              restart_i,
    input  logic [FREQ_W-1:0] freq_code_i,
    input  logic [LVL_W-1:0]  lvl_code_i,
    output logic              bs_o
);
    localparam int unsigned ACC_W = FRAC_W + GUARD_W;
    localparam logic [FREQ_W-1:0] FREQ_RST = FREQ_W'(DEF_FREQ_CODE);
    localparam logic [LVL_W-1:0]  LVL_RST  = LVL_W'(DEF_LVL_CODE);

    typedef struct packed {
        run_state_e        state;
        logic [FREQ_W-1:0] freq;
        logic [LVL_W-1:0]  lvl;
        logic              bs;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic idle, seed, q_bit;
    logic [LVL_W-1:0] seed_lvl;
    logic signed [ACC_W-1:0] x1_w, x2_w, resid_w;

    always_comb begin
        c_d      = c_q;
        idle     = pwr_down_i | ext_sel_i;
        seed     = !idle && ((c_q.state == ST_IDLE) || restart_i);
        seed_lvl = restart_i ? lvl_code_i : c_q.lvl;
        // Codes are captured on restart even while idle.
        if (restart_i) begin
            c_d.freq = freq_code_i;
            c_d.lvl  = lvl_code_i;
        end
        if (idle) begin
            c_d.state = ST_IDLE;
            c_d.bs    = 1'b0;
        end else begin
            c_d.state = ST_RUN;
            c_d.bs    = (c_q.state == ST_RUN) ? q_bit : 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{state: ST_IDLE, freq: FREQ_RST, lvl: LVL_RST, bs: 1'b0};
        else         c_q <= c_d;
    end

    dsres_core #(
        .ACC_W(ACC_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W),
        .LVL_W(LVL_W), .K_SHIFT(K_SHIFT)
    ) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (idle),
        .seed_i   (seed),
        .fb_bit_i (q_bit),
        .freq_i   (c_q.freq),
        .lvl_i    (seed_lvl),
        .x1_o     (x1_w),
        .x2_o     (x2_w)
    );

    dsres_quant #(
        .ACC_W(ACC_W), .FRAC_W(FRAC_W)
    ) u_quant (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (idle | seed),
        .x_i     (x2_w),
        .bit_o   (q_bit),
        .resid_o (resid_w)
    );

    assign bs_o = c_q.bs;

endmodule

// File: rtl/dsres_osc_chk.sv
module dsres_osc_chk #(
    parameter int unsigned ACC_W  = 23,
    parameter int unsigned FRAC_W = 20,
    parameter int unsigned FREQ_W = 7,
    parameter int unsigned LVL_W  = 7
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    pwr_down_i,
    input logic                    ext_sel_i,
    input logic                    restart_i,
    input logic [LVL_W-1:0]        lvl_code_i,
    input logic                    bs_i,
    input logic [ACC_W-1:0]        x1_i,
    input logic [ACC_W-1:0]        x2_i,
    input logic signed [ACC_W-1:0] resid_i,
    input logic [FREQ_W-1:0]       freq_cap_i,
    input logic [LVL_W-1:0]        lvl_cap_i
);
    localparam int unsigned SEED_SH = FRAC_W - LVL_W - 1;
    localparam logic signed [ACC_W-1:0] FS_P = ACC_W'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0] FS_N = -FS_P;

    assert_idle_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_down_i |=> !bs_i)
        else $error("power-down did not silence the stream");

    assert_idle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_down_i || ext_sel_i) |=> (x1_i == '0 && x2_i == '0))
        else $error("integrators not cleared while idle");

    assert_ext_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_sel_i |=> !bs_i)
        else $error("external select did not silence the stream");

    assert_seed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_i && !pwr_down_i && !ext_sel_i) |=>
        (x1_i == '0 && x2_i == (ACC_W'($past(lvl_code_i)) << SEED_SH) && resid_i == '0))
        else $error("restart did not reseed the loop");

    assert_hold_codes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !restart_i |=> ($stable(freq_cap_i) && $stable(lvl_cap_i)))
        else $error("codes changed without restart");

    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resid_i >= FS_N) && (resid_i < FS_P))
        else $error("quantizer residue left its range");

endmodule

bind dsres_osc dsres_osc_chk #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .LVL_W(LVL_W)
) u_dsres_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .ext_sel_i  (ext_sel_i),
    .restart_i  (restart_i),
    .lvl_code_i (lvl_code_i),
    .bs_i       (bs_o),
    .x1_i       (x1_w),
    .x2_i       (x2_w),
    .resid_i    (resid_w),
    .freq_cap_i (c_q.freq),
    .lvl_cap_i  (c_q.lvl)
);

// File: tb/dsres_osc_bench.sv
module dsres_osc_bench;
    localparam int WIN  = 64;
    localparam int HYST = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd = 1'b0;
    logic       ext = 1'b0;
    logic       restart = 1'b0;
    logic [6:0] freq = 7'd96;
    logic [6:0] lvl = 7'd64;
    logic       bs;

    always #5 clk = ~clk;

    dsres_osc u_dsres_osc (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pwr_down_i  (pd),
        .ext_sel_i   (ext),
        .restart_i   (restart),
        .freq_code_i (freq),
        .lvl_code_i  (lvl),
        .bs_o        (bs)
    );

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    longint cyc = 0;
    bit     win [WIN];
    int     widx = 0;
    int     fsum = -WIN;
    bit     hi = 1'b0;
    int     ncross = 0;
    longint xt [8];
    int     peak = 0;

    // Bench reconstruction filter: moving sum of +/-1 over WIN samples.
    always @(negedge clk) begin
        cyc++;
        fsum = fsum - (win[widx] ? 1 : -1) + (bs ? 1 : -1);
        win[widx] = bs;
        widx = (widx + 1) % WIN;
        if (!hi && fsum >= HYST) begin
            if (ncross < 8) xt[ncross] = cyc;
            ncross++;
            hi = 1'b1;
        end else if (hi && fsum <= -HYST) begin
            hi = 1'b0;
        end
        if (fsum > peak)  peak = fsum;
        if (-fsum > peak) peak = -fsum;
    end

    function automatic real exp_period(input int code);
        return 2.0 * 3.14159265358979 / $acos(1.0 - real'(code) / 524288.0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic load_codes(input int f, input int l);
        @(negedge clk);
        freq = 7'(f);
        lvl = 7'(l);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic check_low(input int n, input string req);
        bit ok = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (bs) ok = 1'b0;
        end
        check(ok, req, "stream held low", ok ? 0.0 : 1.0, 0.0);
    endtask

    task automatic measure(input int code, input int lv, input string req, input bit amp);
        real expv = exp_period(code);
        int  limit = int'(expv * 12.0) + 2000;
        int  guard = 0;
        bit  armed = 1'b0;
        real per;
        real eamp;
        ncross = 0;
        while (ncross < 7 && guard < limit) begin
            @(posedge clk);
            guard++;
            if (!armed && ncross >= 2) begin
                peak = 0;
                armed = 1'b1;
            end
        end
        if (ncross < 7) begin
            check(1'b0, req, "tone crossings", real'(ncross), 7.0);
        end else begin
            per = real'(xt[6] - xt[2]) / 4.0;
            check((per >= 0.96 * expv) && (per <= 1.04 * expv), req, "tone period", per, expv);
            if (amp) begin
                eamp = real'(lv) / 4.0;
                // R5: peak of filtered swing is about L/256 of full scale (L/4 of a 64-sum)
                check((real'(peak) >= 0.55 * eamp) && (real'(peak) <= 1.35 * eamp),
                      "R5", "tone amplitude", real'(peak), eamp);
            end
        end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2024);
        // R1: reset holds the stream low
        check_low(8, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: defaults (96, 64) start on their own, about 39 kHz at 12.8 MHz
        measure(96, 64, "R1", 1'b1);

        // R4: directed corners, highest code and a low code
        load_codes(127, 100);
        measure(127, 100, "R4", 1'b1);
        load_codes(40, 48);
        measure(40, 48, "R4", 1'b1);

        // R4: constrained random codes
        for (int i = 0; i < 3; i++) begin
            int f;
            int l;
            f = int'($urandom_range(127, 40));
            l = int'($urandom_range(120, 48));
            load_codes(f, l);
            measure(f, l, "R4", 1'b1);
        end

        // R7: input codes change without restart, tone must not move
        load_codes(70, 80);
        measure(70, 80, "R4", 1'b1);
        @(negedge clk);
        freq = 7'd120;
        lvl = 7'd50;
        measure(70, 80, "R7", 1'b1);

        // R2: power-down silences; resume uses captured codes (R7)
        @(negedge clk);
        pd = 1'b1;
        check_low(40, "R2");
        @(negedge clk);
        pd = 1'b0;
        measure(70, 80, "R7", 1'b1);

        // R3: external source selected
        @(negedge clk);
        ext = 1'b1;
        check_low(40, "R3");
        @(negedge clk);
        ext = 1'b0;

        // R6: restart and power-down on the same edge
        @(negedge clk);
        pd = 1'b1;
        freq = 7'd60;
        lvl = 7'd90;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        freq = 7'd110;
        lvl = 7'd50;
        check_low(30, "R6");
        @(negedge clk);
        pd = 1'b0;
        measure(60, 90, "R6", 1'b1);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

endmodule